// File: doc/BRIEF.md
# Dual-Interrupt GPIO Bank with Wakeup

This block is a bank of 32 general-purpose pins behind a 32-bit register port that also takes byte and halfword accesses. Each pin can be made an output, driven from a data-out register, or left as an input. An input pin can flag four kinds of event: a rising edge, a falling edge, a high level and a low level. Each kind is enabled per pin in its own register.

A detected event sets its pin's bit in two separate status registers, A and B. Each status register has its own enable register and its own interrupt line, so one bank can serve two interrupt consumers that acknowledge independently. A third output, `wake`, pulses when an event hits a pin marked for wakeup, but only while the system-configuration register allows wakeup and selects a non-zero idle mode.

Set and clear alias addresses give single-write atomic updates of the data-out register, both enable registers and the wake-enable register. Writing a 1 to the soft-reset bit of the system-configuration register returns the bank to its reset state.

Top module: `gpio_bank`

## Requirements
- R1: Reads at word offsets: 0x00 identity (0x18, or 0x25 when `ALT_ID`=1), 0x10 sysconfig, 0x14 reset-done (reads 1), 0x18/0x1C status A/enable A, 0x20 wake enable, 0x28/0x2C status B/enable B, 0x30 control, 0x34 direction, 0x38 sampled input, 0x3C data out, 0x40 low-level detect, 0x44 high-level detect, 0x48 rising detect, 0x4C falling detect, 0x50/0x54 debounce enable/time (stored only). Offsets 0x00, 0x14 and 0x38 ignore writes.
- R2: An event on pin n sets bit n of both status A and status B. The status bit is set on the second rising clock edge after `pin_in` changes, because the input is sampled once before detection.
- R3: `irq_a` is high when any bit is set in both status A and enable A, and `irq_b` likewise from status B and enable B. Writing 1s at 0x64/0x74 sets enable bits and at 0x60/0x70 clears them. 0 bits are left unchanged.
- R4: Events are recognised only on pins whose direction bit is 1 (input). `pin_drive` equals the inverse of direction, and `pin_out` is data out masked to the driven pins.
- R5: Status bits are write-one-to-clear. A level condition that is still active sets its bit again on the same edge as the clear, so the bit reads back as 1.
- R6: A rising edge counts when its rising-detect bit is 1. A falling edge counts when its falling-detect bit is 1. A pin sampled high counts when its high-level bit is 1, and a pin sampled low counts when its low-level bit is 1.
- R7: `wake` pulses for one cycle after an event on a pin whose wake-enable bit is 1, only if sysconfig bit 2 is 1 and sysconfig bits [4:3] are non-zero.
- R8: Writing sysconfig with bit 1 set resets all enables, detects, status, data out and wake enables, and sets direction to all ones. Sysconfig stores the written value ANDed with 0x1D. Control keeps only bits [2:0].
- R9: Sizes are encoded as 0 byte, 1 halfword and 2 word, and `bus_addr[1:0]` selects the lane. A sub-word write to an ordinary register merges the lane into the current value. A sub-word write to a status, set or clear address places the lane with zeros elsewhere.
- R10: `bus_rdata` is the addressed 32-bit register shifted right by 8 × `bus_addr[1:0]`.
- R11: Writing 1s at 0x94 sets data-out bits and at 0x90 clears them. Writing 1s at 0x84 sets wake-enable bits and at 0x80 clears them.
- R12: After reset, direction reads 0xFFFFFFFF, and status, enables, outputs and `wake` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data, lane value in the low bits |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output levels for driven pins |
| pin_drive | output | 32 | 1 where the pin is driven |
| irq_a | output | 1 | Interrupt A |
| irq_b | output | 1 | Interrupt B |
| wake | output | 1 | Wakeup pulse |

## Verification
The bench checks that clearing a level event while the level persists leaves the status bit set. A design that let the clear win would lose the event. It checks that a byte write to a clear alias touches only its lane; merging the old contents there would wipe the whole data-out register. It checks that output pins raise no events, that acknowledging status A leaves status B set, and that wake stays low when either the pin's wake enable or the sysconfig gate is off. A design that shared one status register, or gated wake on the event alone, would fail these checks.

// File: rtl/gpb_pkg.sv
// Shared constants for the GPIO bank: access sizes, register offsets
// and sysconfig field positions. Assumes an 8-bit byte address.
package gpb_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    localparam logic [7:0] OFF_ID      = 8'h00;
    localparam logic [7:0] OFF_SYSCFG  = 8'h10;
    localparam logic [7:0] OFF_RSTDONE = 8'h14;
    localparam logic [7:0] OFF_STAT_A  = 8'h18;
    localparam logic [7:0] OFF_EN_A    = 8'h1C;
    localparam logic [7:0] OFF_WKEN    = 8'h20;
    localparam logic [7:0] OFF_STAT_B  = 8'h28;
    localparam logic [7:0] OFF_EN_B    = 8'h2C;
    localparam logic [7:0] OFF_CTRL    = 8'h30;
    localparam logic [7:0] OFF_DIR     = 8'h34;
    localparam logic [7:0] OFF_DIN     = 8'h38;
    localparam logic [7:0] OFF_DOUT    = 8'h3C;
    localparam logic [7:0] OFF_LVL_LO  = 8'h40;
    localparam logic [7:0] OFF_LVL_HI  = 8'h44;
    localparam logic [7:0] OFF_RISE    = 8'h48;
    localparam logic [7:0] OFF_FALL    = 8'h4C;
    localparam logic [7:0] OFF_DB_EN   = 8'h50;
    localparam logic [7:0] OFF_DB_TIME = 8'h54;
    localparam logic [7:0] OFF_EN_A_CLR = 8'h60;
    localparam logic [7:0] OFF_EN_A_SET = 8'h64;
    localparam logic [7:0] OFF_EN_B_CLR = 8'h70;
    localparam logic [7:0] OFF_EN_B_SET = 8'h74;
    localparam logic [7:0] OFF_WK_CLR  = 8'h80;
    localparam logic [7:0] OFF_WK_SET  = 8'h84;
    localparam logic [7:0] OFF_DO_CLR  = 8'h90;
    localparam logic [7:0] OFF_DO_SET  = 8'h94;

    localparam logic [7:0] CFG_KEEP     = 8'h1D;
    localparam int unsigned CFG_SRST_BIT = 1;
    localparam int unsigned CFG_WAKE_BIT = 2;
    localparam logic [7:0] ID_BASE      = 8'h18;
    localparam logic [7:0] ID_ALT       = 8'h25;
endpackage

// File: rtl/gpb_wr_align.sv
// Sub-word write aligner. It builds the lane mask from the access size and
// address, and returns two values: the lane placed with zeros elsewhere, and
// the lane merged into the current register contents.
// Assumes BUS_W is a multiple of 8 and at least 16.
module gpb_wr_align
    import gpb_pkg::*;
#(
    parameter int unsigned BUS_W = 32,
    localparam int unsigned LANE_W = $clog2(BUS_W / 8)
) (
    input  logic [1:0]        size,
    input  logic [LANE_W-1:0] lane,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [BUS_W-1:0]  cur,
    output logic [BUS_W-1:0]  placed,
    output logic [BUS_W-1:0]  merged
);
    logic [BUS_W-1:0]       mask;
    logic [LANE_W+2:0]      sh;

    // Lane mask and shift amount chosen by the access size.
    always_comb begin
        case (size)
            SZ_BYTE: mask = {{(BUS_W-8){1'b0}}, 8'hFF};
            SZ_HALF: mask = {{(BUS_W-16){1'b0}}, 16'hFFFF};
            default: mask = '1;
        endcase
        sh = (size == SZ_WORD) ? '0 : {lane, 3'b000};
    end

    // Lane-only value and read-modify-write value.
    always_comb begin
        placed = (wdata & mask) << sh;
        merged = (cur & ~(mask << sh)) | placed;
    end
endmodule

// File: rtl/gpb_detect.sv
// Event detector. It samples the pads once per clock and compares the
// sample with the previous one to find edges. Level events are taken from
// the current sample. Events are reported only on pins marked as inputs.
// Assumes pin_in is already synchronous to clk.
module gpb_detect #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] sense_en,
    input  logic [W-1:0] lvl_lo,
    input  logic [W-1:0] lvl_hi,
    input  logic [W-1:0] edge_rise,
    input  logic [W-1:0] edge_fall,
    output logic [W-1:0] sampled,
    output logic [W-1:0] evt
);
    logic [W-1:0] prev_q;

    // Two-deep history of the pad levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sampled <= '0;
            prev_q  <= '0;
        end else begin
            sampled <= pin_in;
            prev_q  <= sampled;
        end
    end

    // Per-pin event: any enabled edge or level condition on an input pin.
    always_comb begin
        evt = sense_en & ((sampled & ~prev_q & edge_rise)
                        | (~sampled & prev_q & edge_fall)
                        | (sampled & lvl_hi)
                        | (~sampled & lvl_lo));
    end
endmodule

// File: rtl/gpb_status.sv
// One status/enable pair with its interrupt line. Events set status bits,
// and a write of ones clears them. When an event and a clear hit the same
// bit on the same edge, the event wins, so a persisting level re-arms at
// once. The enable register takes direct loads and set/clear aliases.
module gpb_status #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_clr,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] w1c,
    input  logic         en_load,
    input  logic [W-1:0] en_val,
    input  logic [W-1:0] en_set,
    input  logic [W-1:0] en_clr,
    output logic [W-1:0] stat,
    output logic [W-1:0] en,
    output logic         irq
);
    // Status: clear by write-one, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) stat <= '0;
        else                    stat <= (stat & ~w1c) | evt;
    end

    // Enable: direct load, or set and clear through the aliases.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) en <= '0;
        else if (en_load)       en <= en_val;
        else                    en <= (en | en_set) & ~en_clr;
    end

    assign irq = |(stat & en);

    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) && !soft_clr |=> ((stat & $past(evt)) == $past(evt)));

    assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(w1c & ~evt)) && !soft_clr |=> ((stat & $past(w1c & ~evt)) == '0));

    assert_soft_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (stat == '0) && (en == '0));
endmodule

// File: rtl/gpio_bank.sv
// GPIO bank top. It holds the register file, decodes bus writes (including
// sub-word accesses and set/clear aliases) and muxes reads. It feeds the
// event detector and fans its events out to two status/enable pairs. It
// also generates the idle-gated wake pulse. Reads are combinational from
// bus_addr, and writes take effect on the clock edge where bus_wr is high.
module gpio_bank
    import gpb_pkg::*;
#(
    parameter int unsigned BUS_W  = 32,
    parameter bit          ALT_ID = 1'b0,
    localparam int unsigned LANE_W = $clog2(BUS_W / 8),
    localparam int unsigned NCH    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [7:0]       bus_addr,
    input  logic [1:0]       bus_size,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [BUS_W-1:0] pin_in,
    output logic [BUS_W-1:0] pin_out,
    output logic [BUS_W-1:0] pin_drive,
    output logic             irq_a,
    output logic             irq_b,
    output logic             wake
);
    logic [7:0]       word_off;
    logic [BUS_W-1:0] rd_word, placed, merged;
    logic [7:0]       cfg_q;
    logic [2:0]       ctrl_q;
    logic [7:0]       db_time_q;
    logic [BUS_W-1:0] dir_q, dout_q, wken_q, lvl_lo_q, lvl_hi_q;
    logic [BUS_W-1:0] rise_q, fall_q, db_en_q, sampled, evt;
    logic [BUS_W-1:0] stat_v [NCH];
    logic [BUS_W-1:0] en_v   [NCH];
    logic             irq_v  [NCH];
    logic             soft_clr, hit_cfg;

    assign word_off = {bus_addr[7:2], 2'b00};
    assign hit_cfg  = bus_wr && (word_off == OFF_SYSCFG);

    gpb_wr_align #(.BUS_W(BUS_W)) u_align (
        .size   (bus_size),
        .lane   (bus_addr[LANE_W-1:0]),
        .wdata  (bus_wdata),
        .cur    (rd_word),
        .placed (placed),
        .merged (merged)
    );

    assign soft_clr = hit_cfg && merged[CFG_SRST_BIT];

    gpb_detect #(.W(BUS_W)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .sense_en  (dir_q),
        .lvl_lo    (lvl_lo_q),
        .lvl_hi    (lvl_hi_q),
        .edge_rise (rise_q),
        .edge_fall (fall_q),
        .sampled   (sampled),
        .evt       (evt)
    );

    // Two status/enable channels share the same events.
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        localparam logic [7:0] O_ST  = (g == 0) ? OFF_STAT_A   : OFF_STAT_B;
        localparam logic [7:0] O_EN  = (g == 0) ? OFF_EN_A     : OFF_EN_B;
        localparam logic [7:0] O_SET = (g == 0) ? OFF_EN_A_SET : OFF_EN_B_SET;
        localparam logic [7:0] O_CLR = (g == 0) ? OFF_EN_A_CLR : OFF_EN_B_CLR;
        logic [BUS_W-1:0] w1c, en_set, en_clr;
        logic             en_load;

        assign w1c     = (bus_wr && word_off == O_ST)  ? placed : '0;
        assign en_set  = (bus_wr && word_off == O_SET) ? placed : '0;
        assign en_clr  = (bus_wr && word_off == O_CLR) ? placed : '0;
        assign en_load = bus_wr && (word_off == O_EN);

        gpb_status #(.W(BUS_W)) u_stat (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_clr (soft_clr),
            .evt      (evt),
            .w1c      (w1c),
            .en_load  (en_load),
            .en_val   (merged),
            .en_set   (en_set),
            .en_clr   (en_clr),
            .stat     (stat_v[g]),
            .en       (en_v[g]),
            .irq      (irq_v[g])
        );
    end

    assign irq_a = irq_v[0];
    assign irq_b = irq_v[1];

    // Sysconfig: stored masked, and only a hardware reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_q <= '0;
        else if (hit_cfg) cfg_q <= merged[7:0] & CFG_KEEP;
    end

    // Plain read/write registers, returned to defaults by either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            ctrl_q    <= '0;
            dir_q     <= '1;
            lvl_lo_q  <= '0;
            lvl_hi_q  <= '0;
            rise_q    <= '0;
            fall_q    <= '0;
            db_en_q   <= '0;
            db_time_q <= '0;
        end else if (bus_wr) begin
            case (word_off)
                OFF_CTRL:    ctrl_q    <= merged[2:0];
                OFF_DIR:     dir_q     <= merged;
                OFF_LVL_LO:  lvl_lo_q  <= merged;
                OFF_LVL_HI:  lvl_hi_q  <= merged;
                OFF_RISE:    rise_q    <= merged;
                OFF_FALL:    fall_q    <= merged;
                OFF_DB_EN:   db_en_q   <= merged;
                OFF_DB_TIME: db_time_q <= merged[7:0];
                default: ;
            endcase
        end
    end

    // Data out: direct load or set/clear aliases.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr)                 dout_q <= '0;
        else if (bus_wr && word_off == OFF_DOUT)   dout_q <= merged;
        else if (bus_wr && word_off == OFF_DO_SET) dout_q <= dout_q | placed;
        else if (bus_wr && word_off == OFF_DO_CLR) dout_q <= dout_q & ~placed;
    end

    // Wake enable: direct load or set/clear aliases.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr)                 wken_q <= '0;
        else if (bus_wr && word_off == OFF_WKEN)   wken_q <= merged;
        else if (bus_wr && word_off == OFF_WK_SET) wken_q <= wken_q | placed;
        else if (bus_wr && word_off == OFF_WK_CLR) wken_q <= wken_q & ~placed;
    end

    // Wake pulse: event on a wake pin while wakeup and an idle mode are on.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) wake <= 1'b0;
        else wake <= (|(evt & wken_q)) && cfg_q[CFG_WAKE_BIT] && (|cfg_q[4:3]);
    end

    assign pin_drive = ~dir_q;
    assign pin_out   = dout_q & ~dir_q;

    // Read mux for the addressed word; aliases read their target register.
    always_comb begin
        case (word_off)
            OFF_ID:      rd_word = BUS_W'(ALT_ID ? ID_ALT : ID_BASE);
            OFF_SYSCFG:  rd_word = BUS_W'(cfg_q);
            OFF_RSTDONE: rd_word = BUS_W'(1);
            OFF_STAT_A:  rd_word = stat_v[0];
            OFF_EN_A, OFF_EN_A_SET, OFF_EN_A_CLR: rd_word = en_v[0];
            OFF_WKEN, OFF_WK_SET, OFF_WK_CLR:     rd_word = wken_q;
            OFF_STAT_B:  rd_word = stat_v[1];
            OFF_EN_B, OFF_EN_B_SET, OFF_EN_B_CLR: rd_word = en_v[1];
            OFF_CTRL:    rd_word = BUS_W'(ctrl_q);
            OFF_DIR:     rd_word = dir_q;
            OFF_DIN:     rd_word = sampled;
            OFF_DOUT, OFF_DO_SET, OFF_DO_CLR:     rd_word = dout_q;
            OFF_LVL_LO:  rd_word = lvl_lo_q;
            OFF_LVL_HI:  rd_word = lvl_hi_q;
            OFF_RISE:    rd_word = rise_q;
            OFF_FALL:    rd_word = fall_q;
            OFF_DB_EN:   rd_word = db_en_q;
            OFF_DB_TIME: rd_word = BUS_W'(db_time_q);
            default:     rd_word = '0;
        endcase
    end

    assign bus_rdata = rd_word >> {bus_addr[LANE_W-1:0], 3'b000};

    assert_dir_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt & ~dir_q) == '0);

    assert_wake_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $past(cfg_q[CFG_WAKE_BIT]) && $past(|cfg_q[4:3]));

    assert_irq_needs_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_a |-> (stat_v[0] != '0));
endmodule

// File: tb/gpio_bank_bench.sv
// Self-checking bench for gpio_bank: a vector table walked by one loop,
// then directed tests for pins, interrupts and wake.
module gpio_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_drive;
    logic        irq_a, irq_b, wake;

    int n_chk = 0;
    int n_bad = 0;
    int wake_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_bank u_gpio_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_drive(pin_drive),
        .irq_a(irq_a), .irq_b(irq_b), .wake(wake)
    );

    always @(negedge clk) if (rst_n && wake) wake_cnt <= wake_cnt + 1;

    // Vector: {op[1:0], addr[7:0], size[1:0], data[31:0], exp[31:0], req[7:0]}
    // op 0 = write, 1 = read and compare, 2 = drive pins and settle
    localparam int NV = 64;
    localparam logic [83:0] VEC [NV] = '{
        {2'd1, 8'h00, 2'd2, 32'h0, 32'h18, 8'd1},          // R1 identity
        {2'd1, 8'h14, 2'd2, 32'h0, 32'h1, 8'd1},           // R1 reset done
        {2'd1, 8'h34, 2'd2, 32'h0, 32'hFFFFFFFF, 8'd12},   // R12 all inputs
        {2'd1, 8'h18, 2'd2, 32'h0, 32'h0, 8'd12},          // R12 status clear
        {2'd0, 8'h00, 2'd2, 32'h55, 32'h0, 8'd1},
        {2'd1, 8'h00, 2'd2, 32'h0, 32'h18, 8'd1},          // R1 read-only id
        {2'd0, 8'h38, 2'd2, 32'hFFFF, 32'h0, 8'd1},
        {2'd1, 8'h38, 2'd2, 32'h0, 32'h0, 8'd1},           // R1 read-only input
        {2'd0, 8'h48, 2'd2, 32'h1, 32'h0, 8'd6},
        {2'd2, 8'h00, 2'd2, 32'h1, 32'h0, 8'd2},
        {2'd1, 8'h18, 2'd2, 32'h0, 32'h1, 8'd2},           // R2 status A
        {2'd1, 8'h28, 2'd2, 32'h0, 32'h1, 8'd2},           // R2 status B
        {2'd0, 8'h18, 2'd2, 32'h1, 32'h0, 8'd5},
        {2'd1, 8'h18, 2'd2, 32'h0, 32'h0, 8'd5},           // R5 cleared A
        {2'd1, 8'h28, 2'd2, 32'h0, 32'h1, 8'd5},           // R5 B untouched
        {2'd0, 8'h28, 2'd2, 32'h1, 32'h0, 8'd5},
        {2'd1, 8'h28, 2'd2, 32'h0, 32'h0, 8'd5},           // R5 cleared B
        {2'd0, 8'h4C, 2'd2, 32'h2, 32'h0, 8'd6},
        {2'd2, 8'h00, 2'd2, 32'h3, 32'h0, 8'd6},
        {2'd1, 8'h18, 2'd2, 32'h0, 32'h0, 8'd6},           // R6 no rise detect
        {2'd2, 8'h00, 2'd2, 32'h1, 32'h0, 8'd6},
        {2'd1, 8'h18, 2'd2, 32'h0, 32'h2, 8'd6},           // R6 falling edge
        {2'd0, 8'h18, 2'd2, 32'hFFFFFFFF, 32'h0, 8'd5},
        {2'd0, 8'h28, 2'd2, 32'hFFFFFFFF, 32'h0, 8'd5},
        {2'd0, 8'h44, 2'd2, 32'h4, 32'h0, 8'd6},
        {2'd2, 8'h00, 2'd2, 32'h5, 32'h0, 8'd6},
        {2'd1, 8'h18, 2'd2, 32'h0, 32'h4, 8'd6},           // R6 high level
        {2'd0, 8'h18, 2'd2, 32'h4, 32'h0, 8'd5},
        {2'd1, 8'h18, 2'd2, 32'h0, 32'h4, 8'd5},           // R5 level re-arms
        {2'd0, 8'h44, 2'd2, 32'h0, 32'h0, 8'd5},
        {2'd0, 8'h18, 2'd2, 32'h4, 32'h0, 8'd5},
        {2'd1, 8'h18, 2'd2, 32'h0, 32'h0, 8'd5},           // R5 clear sticks
        {2'd0, 8'h40, 2'd2, 32'h10, 32'h0, 8'd6},
        {2'd1, 8'h18, 2'd2, 32'h0, 32'h10, 8'd6},          // R6 low level
        {2'd0, 8'h40, 2'd2, 32'h0, 32'h0, 8'd6},
        {2'd0, 8'h18, 2'd2, 32'hFFFFFFFF, 32'h0, 8'd5},
        {2'd0, 8'h28, 2'd2, 32'hFFFFFFFF, 32'h0, 8'd5},
        {2'd0, 8'h34, 2'd2, 32'hFFFFFFF7, 32'h0, 8'd4},
        {2'd0, 8'h48, 2'd2, 32'h9, 32'h0, 8'd4},
        {2'd2, 8'h00, 2'd2, 32'hD, 32'h0, 8'd4},
        {2'd1, 8'h18, 2'd2, 32'h0, 32'h0, 8'd4},           // R4 output pin gated
        {2'd0, 8'h3C, 2'd2, 32'hA5, 32'h0, 8'd11},
        {2'd1, 8'h3C, 2'd2, 32'h0, 32'hA5, 8'd11},         // R11 load
        {2'd0, 8'h94, 2'd2, 32'h100, 32'h0, 8'd11},
        {2'd1, 8'h3C, 2'd2, 32'h0, 32'h1A5, 8'd11},        // R11 set alias
        {2'd0, 8'h90, 2'd2, 32'h5, 32'h0, 8'd11},
        {2'd1, 8'h3C, 2'd2, 32'h0, 32'h1A0, 8'd11},        // R11 clear alias
        {2'd0, 8'h3D, 2'd0, 32'h77, 32'h0, 8'd9},
        {2'd1, 8'h3C, 2'd2, 32'h0, 32'h77A0, 8'd9},        // R9 byte merge
        {2'd0, 8'h3E, 2'd1, 32'hBEEF, 32'h0, 8'd9},
        {2'd1, 8'h3C, 2'd2, 32'h0, 32'hBEEF77A0, 8'd9},    // R9 half merge
        {2'd0, 8'h91, 2'd0, 32'h01, 32'h0, 8'd9},
        {2'd1, 8'h3C, 2'd2, 32'h0, 32'hBEEF76A0, 8'd9},    // R9 alias lane only
        {2'd1, 8'h3E, 2'd1, 32'h0, 32'h0000BEEF, 8'd10},   // R10 half read
        {2'd1, 8'h3D, 2'd0, 32'h0, 32'h00BEEF76, 8'd10},   // R10 byte read
        {2'd0, 8'h1C, 2'd2, 32'h11223344, 32'h0, 8'd9},
        {2'd0, 8'h1D, 2'd0, 32'hAA, 32'h0, 8'd9},
        {2'd1, 8'h1C, 2'd2, 32'h0, 32'h1122AA44, 8'd9},    // R9 enable merge
        {2'd0, 8'h10, 2'd2, 32'hFF, 32'h0, 8'd8},
        {2'd1, 8'h10, 2'd2, 32'h0, 32'h1D, 8'd8},          // R8 masked sysconfig
        {2'd1, 8'h3C, 2'd2, 32'h0, 32'h0, 8'd8},           // R8 data out reset
        {2'd1, 8'h34, 2'd2, 32'h0, 32'hFFFFFFFF, 8'd8},    // R8 direction reset
        {2'd1, 8'h1C, 2'd2, 32'h0, 32'h0, 8'd8},           // R8 enable reset
        {2'd0, 8'h30, 2'd2, 32'hFF, 32'h0, 8'd8}
    };

    task automatic check(input int req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [1:0] sz,
                             input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_check(input int req, input logic [7:0] a,
                             input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, "read", bus_rdata, exp);
    endtask

    task automatic drive_pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int w0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 outputs after reset
        check(12, "irq_a reset", {31'b0, irq_a}, 32'h0);
        check(12, "irq_b reset", {31'b0, irq_b}, 32'h0);
        check(12, "wake reset", {31'b0, wake}, 32'h0);
        check(12, "pin_drive reset", pin_drive, 32'h0);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][83:82])
                2'd0: bus_write(VEC[i][81:74], VEC[i][73:72], VEC[i][71:40]);
                2'd1: bus_check(int'(VEC[i][7:0]), VEC[i][81:74], VEC[i][39:8]);
                default: drive_pins(VEC[i][71:40]);
            endcase
        end
        bus_check(8, 8'h30, 32'h7);   // R8 control keeps bits [2:0]

        // R4 drive pins follow direction and data out
        bus_write(8'h34, 2'd2, 32'hFFFFFF00);
        bus_write(8'h3C, 2'd2, 32'h5A);
        check(4, "pin_drive", pin_drive, 32'h000000FF);
        check(4, "pin_out", pin_out, 32'h0000005A);
        bus_write(8'h34, 2'd2, 32'hFFFFFFFF);
        check(4, "pin_out masked", pin_out, 32'h0);

        // R3 interrupt lines and enable aliases
        drive_pins(32'h0);
        bus_write(8'h48, 2'd2, 32'h1);
        bus_write(8'h64, 2'd2, 32'h1);
        check(3, "irq_a idle", {31'b0, irq_a}, 32'h0);
        drive_pins(32'h1);
        check(3, "irq_a on event", {31'b0, irq_a}, 32'h1);
        check(3, "irq_b not enabled", {31'b0, irq_b}, 32'h0);
        bus_write(8'h74, 2'd2, 32'h1);
        check(3, "irq_b set alias", {31'b0, irq_b}, 32'h1);
        bus_write(8'h60, 2'd2, 32'h1);
        check(3, "irq_a clear alias", {31'b0, irq_a}, 32'h0);
        bus_check(3, 8'h1C, 32'h0);
        bus_write(8'h28, 2'd2, 32'hFFFFFFFF);
        check(3, "irq_b after w1c", {31'b0, irq_b}, 32'h0);
        bus_write(8'h18, 2'd2, 32'hFFFFFFFF);

        // R7 wake gating; sysconfig is 0x1D after the soft reset
        bus_write(8'h84, 2'd2, 32'h2);
        bus_write(8'h48, 2'd2, 32'h3);
        drive_pins(32'h0);
        w0 = wake_cnt;
        drive_pins(32'h1);
        check(7, "wake, pin not enabled", wake_cnt - w0, 0);
        drive_pins(32'h3);
        check(7, "wake pulse", wake_cnt - w0, 1);
        drive_pins(32'h1);
        bus_write(8'h10, 2'd2, 32'h18);
        drive_pins(32'h3);
        check(7, "wake, sysconfig gate off", wake_cnt - w0, 1);
        bus_write(8'h80, 2'd2, 32'h2);
        bus_check(11, 8'h20, 32'h0);  // R11 wake enable clear alias

        finish_run();
    end
endmodule